// File: doc/BRIEF.md
# Handshake Subtractive GCD Unit

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. It sits behind a two-signal handshake. A `req` input asks for a computation. A `f` (finish) output is high whenever the unit is idle and holding a result. When the unit is idle, a request copies both operands into working registers in one clock edge. The unit then spends one cycle per subtraction step. On each step the smaller register is subtracted from the larger. The loop ends when either register reads zero. The non-zero register, or zero if both are zero, is then written to the result register and `f` rises.

The result and `f` stay unchanged until the next accepted request. A neighbouring controller can therefore chain this unit in sequence with others, or run it in parallel with others, using only `req` and `f`. The control path has two states, waiting and computing, and the controller does nothing else.

Top module: `hs_gcd_unit`

## Requirements
- R1: A synchronous active-high `rst` leaves the unit in the waiting state, with `f` = 1 and `result` = 0.
- R2: A request is accepted on a rising clock edge where `req` = 1 and `f` = 1. At that edge the working registers load with `opnd_a` (first) and `opnd_b` (second), and `f` is 0 in the following cycle.
- R3: The value presented when `f` rises again equals gcd(`opnd_a`, `opnd_b`) for the operands sampled at the accepting edge, with gcd(x,0) = x and gcd(0,0) = 0.
- R4: Each compute cycle in which both registers are non-zero performs one step. If first < second, the second becomes second − first; otherwise the first becomes first − second.
- R5: The compute cycle that sees either register at zero ends the loop. It writes the second register to `result` if the first is zero, and the first register otherwise. A zero operand therefore finishes after exactly one compute cycle.
- R6: `f` rises at the same edge that writes the result. The number of cycles with `f` low equals S + 1, where S is the number of subtraction steps, which is the sum of the Euclidean quotients.
- R7: While `f` = 1 and `req` = 0, `result` and `f` hold their values, whatever the operand inputs do.
- R8: While `f` = 0, `req` and the operand inputs are ignored, and the pending result is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request for a new computation |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| f | output | 1 | Finish: high while idle and a result is held |
| result | output | WIDTH | Greatest common divisor of the last accepted pair |

## Verification
The hardest situation to reach is the longest iteration. The operand pair (65535, 1) forces 65535 single-unit subtractions before the exit test fires. The bench drives this pair directly and checks both the result and the exact count of cycles with `f` low. It also checks the exact number of compute cycles for every pair in a sweep of small operands. Each expected count comes from the sum of Euclidean quotients, so a wrong step rule or an early or late exit shows up as a cycle-count error and not only as a wrong value. The bench also toggles `req` and the operands in the middle of a long computation, to confirm that nothing enters the pending result.

// File: rtl/hs_gcd_pkg.sv
package hs_gcd_pkg;
   typedef enum logic {
      ST_WAIT = 1'b0,
      ST_CALC = 1'b1
   } gcd_state_t;
endpackage

// File: rtl/hs_gcd_step.sv
// One subtraction step: compares the two working values and returns the
// values after subtracting the smaller from the larger.
module hs_gcd_step #(
   parameter int WIDTH        = 16,
   parameter bit LT_BY_BORROW = 1'b1
) (
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   output logic             x_lt_y,
   output logic [WIDTH-1:0] x_out,
   output logic [WIDTH-1:0] y_out
);
   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] diff_xy;
   logic [WIDTH-1:0] diff_yx;

   assign diff_xy = {1'b0, x_in} - {1'b0, y_in};
   assign diff_yx = y_in - x_in;

   generate
      if (LT_BY_BORROW) begin : g_borrow
         assign x_lt_y = diff_xy[EXT_W-1];
      end else begin : g_compare
         assign x_lt_y = (x_in < y_in);
      end
   endgenerate

   always_comb begin
      if (x_lt_y) begin
         x_out = x_in;
         y_out = diff_yx;
      end else begin
         x_out = diff_xy[WIDTH-1:0];
         y_out = y_in;
      end
   end
endmodule

// File: rtl/hs_gcd_ctrl.sv
// Two-state handshake controller: waiting (f high) and computing.
module hs_gcd_ctrl
   import hs_gcd_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic zero_hit,
   output logic accept,
   output logic running,
   output logic f
);
   gcd_state_t state_q, state_d;

   assign f       = (state_q == ST_WAIT);
   assign running = (state_q == ST_CALC);
   assign accept  = f && req;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WAIT: if (req)      state_d = ST_CALC;
         ST_CALC: if (zero_hit) state_d = ST_WAIT;
         default:               state_d = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_WAIT;
      else     state_q <= state_d;
   end

   AST_F_DROPS_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (f && req) |=> !f); // R2

   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
      (f && !req) |=> f); // R7

   AST_NO_EXIT_BEFORE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (running && !zero_hit) |=> !f); // R5
endmodule

// File: rtl/hs_gcd_datapath.sv
// Working registers, step logic, exit test and result register.
module hs_gcd_datapath #(
   parameter int WIDTH        = 16,
   parameter bit LT_BY_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             running,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic             zero_hit,
   output logic [WIDTH-1:0] result
);
   localparam int SUM_W = WIDTH + 1;

   logic [WIDTH-1:0] r1_q, r2_q;
   logic [WIDTH-1:0] r1_nx, r2_nx;
   logic [WIDTH-1:0] res_q;
   logic             r1_lt_r2;
   logic             r1_zero;
   logic             finish;
   logic [SUM_W-1:0] reg_sum;

   hs_gcd_step #(
      .WIDTH        (WIDTH),
      .LT_BY_BORROW (LT_BY_BORROW)
   ) u_step (
      .x_in   (r1_q),
      .y_in   (r2_q),
      .x_lt_y (r1_lt_r2),
      .x_out  (r1_nx),
      .y_out  (r2_nx)
   );

   assign r1_zero  = (r1_q == '0);
   assign zero_hit = r1_zero || (r2_q == '0);
   assign finish   = running && zero_hit;
   assign reg_sum  = {1'b0, r1_q} + {1'b0, r2_q};
   assign result   = res_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         r1_q <= '0;
         r2_q <= '0;
      end else if (accept) begin
         r1_q <= opnd_a;
         r2_q <= opnd_b;
      end else if (running && !zero_hit) begin
         r1_q <= r1_nx;
         r2_q <= r2_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         res_q <= '0;
      else if (finish) res_q <= r1_zero ? r2_q : r1_q;
   end

   AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (rst)
      accept |=> (r1_q == $past(opnd_a)) && (r2_q == $past(opnd_b))); // R2

   AST_STEP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
      (running && !zero_hit) |=> (reg_sum < $past(reg_sum))); // R4

   AST_ONE_REG_MOVES: assert property (@(posedge clk) disable iff (rst)
      (running && !zero_hit) |=> ($stable(r1_q) != $stable(r2_q))); // R4

   AST_RESULT_ONLY_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
      !finish |=> $stable(res_q)); // R7
endmodule

// File: rtl/hs_gcd_unit.sv
// Top level: handshake-wrapped subtractive GCD.
module hs_gcd_unit #(
   parameter int WIDTH        = 16,
   parameter bit LT_BY_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic             f,
   output logic [WIDTH-1:0] result
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("hs_gcd_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic accept;
   logic running;
   logic zero_hit;

   hs_gcd_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .req      (req),
      .zero_hit (zero_hit),
      .accept   (accept),
      .running  (running),
      .f        (f)
   );

   hs_gcd_datapath #(
      .WIDTH        (WIDTH),
      .LT_BY_BORROW (LT_BY_BORROW)
   ) u_dp (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .running  (running),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .zero_hit (zero_hit),
      .result   (result)
   );

   AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
      (!f && !zero_hit) |=> !f); // R8

   AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (f && !req) |=> $stable(result)); // R7
endmodule

// File: tb/hs_gcd_unit_bench.sv
module hs_gcd_unit_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req = 1'b0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic         f;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;
   bit timed_out = 1'b0;

   always #2.5 clk = ~clk;

   hs_gcd_unit #(.WIDTH(W)) u_hs_gcd_unit (
      .clk    (clk),
      .rst    (rst),
      .req    (req),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .f      (f),
      .result (result)
   );

   function automatic int ref_gcd(input int a, input int b);
      int x = a;
      int y = b;
      while (y != 0) begin
         int t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // Subtraction steps = sum of Euclidean quotients (zero when an operand is 0).
   function automatic int ref_steps(input int a, input int b);
      int x = a;
      int y = b;
      int s = 0;
      if (x == 0 || y == 0) return 0;
      while (y != 0) begin
         int t = x % y;
         s = s + x / y;
         x = y;
         y = t;
      end
      return s;
   endfunction

   task automatic check(input bit ok, input string req_tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
      end
   endtask

   // Runs one computation; optionally disturbs inputs while busy.
   task automatic run_pair(input int a, input int b, input bit disturb);
      int low_cycles = 0;
      @(negedge clk);
      opnd_a = a[W-1:0];
      opnd_b = b[W-1:0];
      req    = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check(f == 1'b0, "R2 f low after accept", int'(f), 0);
      while (!f && !timed_out) begin
         low_cycles++;
         if (disturb) begin
            req    = 1'b1;
            opnd_a = opnd_a ^ 16'h5a5a;
            opnd_b = opnd_b + 16'd7;
         end
         @(negedge clk);
      end
      req = 1'b0;
      check(int'(result) == ref_gcd(a, b), "R3/R5 result", int'(result), ref_gcd(a, b));
      check(low_cycles == ref_steps(a, b) + 1, "R4/R6 compute cycles", low_cycles,
            ref_steps(a, b) + 1);
      if (disturb)
         check(int'(result) == ref_gcd(a, b), "R8 busy req ignored", int'(result), ref_gcd(a, b));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      timed_out = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(f == 1'b1, "R1 f after reset", int'(f), 1);
      check(result == '0, "R1 result after reset", int'(result), 0);

      // R5 zero-operand corners
      run_pair(0, 0, 1'b0);
      run_pair(0, 37, 1'b0);
      run_pair(41, 0, 1'b0);

      // R3 sweep of small pairs
      for (int i = 0; i <= 12; i++)
         for (int j = 0; j <= 12; j++)
            run_pair(i, j, 1'b0);

      // R7 hold while idle: operands change, no request
      held = int'(result);
      for (int k = 0; k < 6; k++) begin
         opnd_a = 16'(k * 911 + 3);
         opnd_b = 16'(k * 77 + 1);
         @(negedge clk);
         check(f == 1'b1, "R7 f held", int'(f), 1);
         check(int'(result) == held, "R7 result held", int'(result), held);
      end

      // R8 disturbance during a long run
      run_pair(1000, 3, 1'b1);
      run_pair(40000, 24000, 1'b0);
      run_pair(65535, 65535, 1'b0);
      run_pair(65535, 1, 1'b0);
      run_pair(1, 65535, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule